// File: doc/BRIEF.md
# Searchable In-Order Hazard Scoreboard

This block holds the destination register of every instruction that has passed decode and has not yet committed. Each decoded instruction pushes one entry. An instruction that writes no register still pushes an entry, with its valid tag cleared, so that entries and commits stay in the same order. The commit stage pops the oldest entry.

Decode checks its two source operands against the stored entries through two independent, combinational search ports. A port reports a hazard only when the queried source is valid, an entry is valid, and their register indices match. When a commit and a search fall in the same cycle, the commit applies first. The committing entry is therefore hidden from that search, and a dependent instruction can issue in the same cycle as its producer commits.

The queue depth is a parameter. A depth of one suits a two-stage pipeline in which only one instruction sits in execute.

Top module: `hazard_scoreboard`

## Requirements
- R1: After a cycle with `rst` high, the queue is empty: `empty`=1, `full`=0, and both search ports report no hazard.
- R2: A search port reports a hazard only when its query valid bit is 1, at least one visible entry has its valid tag set, and that entry's 5-bit index equals the query index. An entry pushed with `ins_vld`=0 never matches.
- R3: The two search ports evaluate independently in the same cycle, and each port gives its own result.
- R4: An accepted insert becomes visible to search from the next cycle, not in the cycle it is pushed. An entry with no destination still takes a slot.
- R5: A remove on a non-empty queue deletes the oldest entry. A search in the same cycle already excludes that entry.
- R6: The same register index may sit in several entries. Its hazard stays reported until the last matching entry has been removed.
- R7: When the queue is full, an insert without a same-cycle remove is dropped. An insert together with a remove on a full queue is accepted.
- R8: A remove on an empty queue changes nothing, and `rem_err` is 1 in that cycle. An insert in the same cycle is still accepted.
- R9: `full` is 1 exactly when DEPTH entries are held, and `empty` is 1 exactly when none are held. This also holds for DEPTH=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_en | input | 1 | Push an entry for an instruction leaving decode |
| ins_vld | input | 1 | The pushed instruction writes a register |
| ins_idx | input | 5 | Destination register index |
| rem_en | input | 1 | Pop the oldest entry on commit |
| src_a_vld | input | 1 | Query A is a real source operand |
| src_a_idx | input | 5 | Query A register index |
| src_b_vld | input | 1 | Query B is a real source operand |
| src_b_idx | input | 5 | Query B register index |
| hit_a | output | 1 | Hazard found for query A |
| hit_b | output | 1 | Hazard found for query B |
| full | output | 1 | DEPTH entries held |
| empty | output | 1 | No entries held |
| rem_err | output | 1 | Remove requested while empty |

## Verification
The bench searches for a register in the same cycle that its producer commits. A design that orders search before remove reports a stall there.

The bench stores the same index twice and then removes one copy. Logic that clears the hazard on the first removal lets a dependent instruction through too early.

The bench inserts into a full queue both with and without a same-cycle remove, including at depth one. A wrong full check either overwrites the oldest entry or stalls the pipeline for good.

It also removes from an empty queue while inserting, which shows whether the pointers get corrupted or the insert is lost.

// File: rtl/hsb_pkg.sv
package hsb_pkg;

    localparam int REG_W = 5;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] idx;
    } rtag_t;

    function automatic logic tag_hit(rtag_t entry, rtag_t query);
        return entry.vld && query.vld && (entry.idx == query.idx);
    endfunction

endpackage

// File: rtl/hsb_ptr_ctrl.sv
module hsb_ptr_ctrl #(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_req,
    input  logic             rem_req,
    output logic             ins_fire,
    output logic             rem_fire,
    output logic [PW-1:0]    tail,
    output logic [DEPTH-1:0] visible,
    output logic             full,
    output logic             empty,
    output logic             rem_err
);

    logic [PW-1:0] head;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign full     = (count == CW'(DEPTH));
    assign empty    = (count == '0);
    assign rem_fire = rem_req && !empty;
    assign ins_fire = ins_req && (!full || rem_fire);
    assign rem_err  = rem_req && empty;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            int off;
            off = (i >= int'(head)) ? i - int'(head) : i + DEPTH - int'(head);
            visible[i] = (off < int'(count)) && !(rem_fire && off == 0);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (rem_fire) head <= bump(head);
            if (ins_fire) tail <= bump(tail);
            case ({ins_fire, rem_fire})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/hsb_entry_store.sv
module hsb_entry_store
    import hsb_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_ptr,
    input  rtag_t         wr_tag,
    output rtag_t         slots [DEPTH]
);

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slots[g] <= '0;
            else if (wr_en && wr_ptr == PW'(g))
                slots[g] <= wr_tag;
        end
    end

endmodule

// File: rtl/hsb_search_port.sv
module hsb_search_port
    import hsb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  rtag_t            slots [DEPTH],
    input  logic [DEPTH-1:0] visible,
    input  rtag_t            query,
    output logic             hit
);

    logic [DEPTH-1:0] match;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        assign match[g] = visible[g] && tag_hit(slots[g], query);
    end

    assign hit = |match;

endmodule

// File: rtl/hazard_scoreboard.sv
module hazard_scoreboard
    import hsb_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ins_en,
    input  logic             ins_vld,
    input  logic [REG_W-1:0] ins_idx,
    input  logic             rem_en,
    input  logic             src_a_vld,
    input  logic [REG_W-1:0] src_a_idx,
    input  logic             src_b_vld,
    input  logic [REG_W-1:0] src_b_idx,
    output logic             hit_a,
    output logic             hit_b,
    output logic             full,
    output logic             empty,
    output logic             rem_err
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             ins_fire;
    logic             rem_fire;
    logic [PW-1:0]    tail;
    logic [DEPTH-1:0] visible;
    rtag_t            slots [DEPTH];
    rtag_t            q_a, q_b, new_tag;

    assign new_tag = '{vld: ins_vld, idx: ins_idx};
    assign q_a     = '{vld: src_a_vld, idx: src_a_idx};
    assign q_b     = '{vld: src_b_vld, idx: src_b_idx};

    hsb_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .ins_req  (ins_en),
        .rem_req  (rem_en),
        .ins_fire (ins_fire),
        .rem_fire (rem_fire),
        .tail     (tail),
        .visible  (visible),
        .full     (full),
        .empty    (empty),
        .rem_err  (rem_err)
    );

    hsb_entry_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (ins_fire),
        .wr_ptr (tail),
        .wr_tag (new_tag),
        .slots  (slots)
    );

    hsb_search_port #(.DEPTH(DEPTH)) u_srch_a (
        .slots   (slots),
        .visible (visible),
        .query   (q_a),
        .hit     (hit_a)
    );

    hsb_search_port #(.DEPTH(DEPTH)) u_srch_b (
        .slots   (slots),
        .visible (visible),
        .query   (q_b),
        .hit     (hit_b)
    );

endmodule

// File: rtl/hsb_checker.sv
module hsb_checker (
    input logic       clk,
    input logic       rst,
    input logic       ins_en,
    input logic       ins_vld,
    input logic [4:0] ins_idx,
    input logic       rem_en,
    input logic       src_a_vld,
    input logic [4:0] src_a_idx,
    input logic       src_b_vld,
    input logic [4:0] src_b_idx,
    input logic       hit_a,
    input logic       hit_b,
    input logic       full,
    input logic       empty,
    input logic       rem_err
);

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (empty && !full)); // R1
    AST_NO_HIT_WHEN_EMPTY: assert property (@(posedge clk) disable iff (rst) empty |-> (!hit_a && !hit_b)); // R2
    AST_INVALID_QUERY_A: assert property (@(posedge clk) disable iff (rst) !src_a_vld |-> !hit_a); // R2
    AST_INVALID_QUERY_B: assert property (@(posedge clk) disable iff (rst) !src_b_vld |-> !hit_b); // R3
    AST_INSERT_LANDS: assert property (@(posedge clk) disable iff (rst) (ins_en && !full) |=> !empty); // R4
    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (rst) (full && ins_en && !rem_en) |=> full); // R7
    AST_EMPTY_REMOVE_NOOP: assert property (@(posedge clk) disable iff (rst) (rem_en && empty && !ins_en) |=> empty); // R8
    AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(full && empty)); // R9

endmodule

bind hazard_scoreboard hsb_checker u_chk (.*);

// File: tb/test_hazard_scoreboard.sv
`timescale 1ns/1ps
module test_hazard_scoreboard;

    logic       clk = 1'b0;
    logic       rst;
    logic       ins_en, ins_vld, rem_en, src_a_vld, src_b_vld;
    logic [4:0] ins_idx, src_a_idx, src_b_idx;
    logic       hit_a, hit_b, full, empty, rem_err;
    logic       d1_hit_a, d1_hit_b, d1_full, d1_empty, d1_rem_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    hazard_scoreboard #(.DEPTH(4)) i_hazard_scoreboard (
        .clk(clk), .rst(rst), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
        .rem_en(rem_en), .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
        .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
        .hit_a(hit_a), .hit_b(hit_b), .full(full), .empty(empty), .rem_err(rem_err)
    );

    hazard_scoreboard #(.DEPTH(1)) i_hazard_scoreboard_d1 (
        .clk(clk), .rst(rst), .ins_en(ins_en), .ins_vld(ins_vld), .ins_idx(ins_idx),
        .rem_en(rem_en), .src_a_vld(src_a_vld), .src_a_idx(src_a_idx),
        .src_b_vld(src_b_vld), .src_b_idx(src_b_idx),
        .hit_a(d1_hit_a), .hit_b(d1_hit_b), .full(d1_full), .empty(d1_empty), .rem_err(d1_rem_err)
    );

    typedef struct packed {
        logic       ie;  logic iv; logic [4:0] ii;
        logic       re;
        logic       av;  logic [4:0] ai;
        logic       bv;  logic [4:0] bi;
        logic       ea;  logic eb; logic ef; logic ee; logic er;
    } vec_t;

    localparam int NV = 13;
    // Outputs are expected before the clock edge that applies the row.
    localparam vec_t VECS [NV] = '{
        '{1,1,5'd3, 0, 1,5'd3, 0,5'd0, 0,0,0,1,0}, // R4 push r3, not seen yet
        '{1,0,5'd3, 0, 1,5'd3, 0,5'd3, 1,0,0,0,0}, // R2 r3 seen; invalid query; push no-dest
        '{1,1,5'd7, 0, 1,5'd5, 1,5'd0, 0,0,0,0,0}, // R2 mismatch / no-dest slot unmatched
        '{1,1,5'd7, 0, 1,5'd7, 1,5'd3, 1,1,0,0,0}, // R3 both ports hit
        '{1,1,5'd9, 0, 1,5'd9, 0,5'd0, 0,0,1,0,0}, // R7 full, push r9 dropped
        '{1,1,5'd9, 1, 1,5'd3, 1,5'd7, 0,1,1,0,0}, // R5 r3 popped same cycle; R7 push accepted
        '{0,0,5'd0, 1, 1,5'd9, 1,5'd3, 1,0,1,0,0}, // R7 r9 present, R5 r3 gone
        '{0,0,5'd0, 1, 1,5'd7, 1,5'd9, 1,1,0,0,0}, // R6 r7 duplicated
        '{0,0,5'd0, 1, 1,5'd7, 1,5'd9, 0,1,0,0,0}, // R6 last r7 popping now
        '{0,0,5'd0, 1, 1,5'd9, 0,5'd0, 0,0,0,0,0}, // R5 final pop
        '{1,1,5'd4, 1, 1,5'd9, 0,5'd0, 0,0,0,1,1}, // R8 pop on empty plus push r4
        '{1,1,5'd1, 0, 1,5'd4, 0,5'd0, 1,0,0,0,0}, // R8 push kept
        '{0,0,5'd0, 0, 1,5'd1, 1,5'd4, 1,1,0,0,0}  // R9 two entries, order intact
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic ie, input logic iv, input logic [4:0] ii, input logic re,
                         input logic av, input logic [4:0] ai, input logic bv, input logic [4:0] bi);
        ins_en = ie; ins_vld = iv; ins_idx = ii; rem_en = re;
        src_a_vld = av; src_a_idx = ai; src_b_vld = bv; src_b_idx = bi;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        drive(0,0,0,0,0,0,0,0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        drive(0,0,0,0,1,5'd0,1,5'd0);
        #2;
        check("R1 empty", empty, 1);
        check("R1 full", full, 0);
        check("R1 hits", {hit_a, hit_b}, 0);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            drive(VECS[k].ie, VECS[k].iv, VECS[k].ii, VECS[k].re,
                  VECS[k].av, VECS[k].ai, VECS[k].bv, VECS[k].bi);
            #2;
            check($sformatf("R2-table row %0d hit_a", k), hit_a, VECS[k].ea);
            check($sformatf("R3-table row %0d hit_b", k), hit_b, VECS[k].eb);
            check($sformatf("R9-table row %0d full", k), full, VECS[k].ef);
            check($sformatf("R9-table row %0d empty", k), empty, VECS[k].ee);
            check($sformatf("R8-table row %0d rem_err", k), rem_err, VECS[k].er);
        end

        // R1: reset with entries present
        @(negedge clk);
        drive(0,0,0,0,0,0,0,0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        drive(0,0,0,0,1,5'd4,1,5'd1);
        #2;
        check("R1 reset empty", empty, 1);
        check("R1 reset hits", {hit_a, hit_b}, 0);
        check("R1 depth1 empty", d1_empty, 1);

        // R9: depth-1 instance
        @(negedge clk);
        drive(1,1,5'd2,0,1,5'd2,0,0);
        #2;
        check("R4 depth1 not yet", d1_hit_a, 0);
        @(negedge clk);
        drive(1,1,5'd6,0,1,5'd2,0,0);
        #2;
        check("R9 depth1 full", d1_full, 1);
        check("R9 depth1 empty", d1_empty, 0);
        check("R2 depth1 hit", d1_hit_a, 1);
        @(negedge clk);
        drive(1,1,5'd6,1,1,5'd2,1,5'd6);
        #2;
        check("R5 depth1 popped hidden", d1_hit_a, 0);
        check("R7 depth1 dropped push", d1_hit_b, 0);
        @(negedge clk);
        drive(0,0,0,0,1,5'd6,1,5'd2);
        #2;
        check("R7 depth1 push with pop", d1_hit_a, 1);
        check("R5 depth1 old gone", d1_hit_b, 0);
        check("R9 depth1 still full", d1_full, 1);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule